// File: doc/BRIEF.md
# Masked Memory Region Hit Decoder

This block decides, for each bus access, which of two programmed memory regions the access falls into. Each region has a base register and a mask register, and both are written and read through a simple register port. The mask register holds four things: an address mask, a write-protect control, one disable bit for each access type, and a valid bit. An address bit whose mask bit is set is ignored in the comparison. The ignored bits need not be contiguous.

An access presents its address, a write flag and a one-hot access-type code. The block replies in the same cycle with at most one region hit, a write-protect violation flag, or a miss. Region 0 has precedence when both regions match. A write that lands in a protected region is reported as a violation and never as a hit. Register writes take effect on the next clock edge.

Top module: `mem_region_decoder`

## Requirements
- R1: After reset every base and mask register reads as zero. Every valid bit is therefore clear, and the outputs show `miss`=1 with no hit and no violation.
- R2: Region n has its base register at offset 0x48+8n and its mask register at 0x4C+8n, so the mask registers sit at 0x4C and 0x54. A register is written on a clock edge while `regWrEn` is 1. `regRdData` shows the register addressed by `regAddr` combinationally, and an unmapped offset reads as zero.
- R3: Unimplemented bits read as zero. In a base register these are bits 17..0. In a mask register they are bits 17..9 and bit 7.
- R4: A region matches when ((accAddr[31:18] XOR base[31:18]) AND NOT mask[31:18]) is zero. Each mask bit acts on its own bit position, so non-contiguous masks work.
- R5: A region whose valid bit (mask bit 0) is 0 never hits and never causes a violation.
- R6: The access-type input is one-hot. Bit 5 is CPU space or interrupt acknowledge, bit 4 alternate master, bit 3 supervisor code, bit 2 supervisor data, bit 1 user code and bit 0 user data. Mask bit k+1 disables type bit k. A region whose disable bit for the current type is set does not take part.
- R7: Mask bit 8 is write protect. A write that matches a protected region raises `wpViolation` and asserts no hit. A read of the same region still hits.
- R8: Only the lowest-numbered taking-part region decides the result, so `regionHit` is never more than one-hot. If that region is a protected region under a write, a violation is reported even when region 1 would match.
- R9: `miss` is 1 exactly when no region hits and there is no violation.
- R10: The access outputs depend combinationally on the current access inputs and on the register contents. A register write affects accesses only from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| accType | input | 6 | One-hot access type (see R6) |
| regionHit | output | 2 | One-hot region hit, bit n for region n |
| wpViolation | output | 1 | Write to a protected matching region |
| miss | output | 1 | No hit and no violation |

## Verification
The bench builds the block with its default parameters: two regions, a 14-bit compare field starting at address bit 18, and registers starting at offset 0x48. With two regions, overlapping programming becomes reachable. That lets the bench exercise the region 0 precedence rule, including the case where a protected region 0 masks a matching region 1. The 14-bit field is narrow enough that random addresses, formed by flipping only masked bits around a base, land on hits and near misses often.

// File: rtl/mem_region_pkg.sv
package mem_region_pkg;
  parameter int unsigned REGION_CNT = 2;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned MASK_LSB = 18;
  parameter int unsigned REG_ADDR_W = 8;
  localparam int unsigned MATCH_W = ADDR_W - MASK_LSB;
  localparam int unsigned TYPE_W = 6;
  localparam int unsigned WP_BIT = 8;

  // Decoded register strobes from control to datapath
  typedef struct packed {
    logic [REGION_CNT-1:0] baseWr;
    logic [REGION_CNT-1:0] maskWr;
    logic [REGION_CNT-1:0] baseRd;
    logic [REGION_CNT-1:0] maskRd;
  } regStrobe_t;
endpackage

// File: rtl/mem_region_ctrl.sv
module mem_region_ctrl
  import mem_region_pkg::*;
#(
  parameter int unsigned BASE_OFS = 'h48
) (
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output regStrobe_t            strobe
);
  localparam int unsigned STRIDE = 8;
  localparam int unsigned MASK_GAP = 4;

  for (genvar i = 0; i < REGION_CNT; i++) begin : gDec
    localparam logic [REG_ADDR_W-1:0] BaseOfs = REG_ADDR_W'(BASE_OFS + STRIDE * i);
    localparam logic [REG_ADDR_W-1:0] MaskOfs = REG_ADDR_W'(BASE_OFS + STRIDE * i + MASK_GAP);
    assign strobe.baseRd[i] = (regAddr == BaseOfs);
    assign strobe.maskRd[i] = (regAddr == MaskOfs);
    assign strobe.baseWr[i] = regWrEn && (regAddr == BaseOfs);
    assign strobe.maskWr[i] = regWrEn && (regAddr == MaskOfs);
  end
endmodule

// File: rtl/mem_region_match.sv
module mem_region_match
  import mem_region_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic [TYPE_W-1:0] accType,
  output logic [REGION_CNT-1:0] regionHit,
  output logic              wpViolation,
  output logic              miss
);
  logic [REGION_CNT-1:0]             candidate;
  logic [REGION_CNT-1:0]             protect;
  logic [REGION_CNT-1:0][ADDR_W-1:0] baseView;
  logic [REGION_CNT-1:0][ADDR_W-1:0] maskView;

  for (genvar i = 0; i < REGION_CNT; i++) begin : gRegion
    logic [MATCH_W-1:0] baseR;
    logic [MATCH_W-1:0] maskR;
    logic [TYPE_W-1:0]  disR;
    logic               wpR;
    logic               validR;
    logic               addrOk;
    logic               typeOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR  <= '0;
        maskR  <= '0;
        disR   <= '0;
        wpR    <= 1'b0;
        validR <= 1'b0;
      end else begin
        if (strobe.baseWr[i]) baseR <= regWrData[ADDR_W-1:MASK_LSB];
        if (strobe.maskWr[i]) begin
          maskR  <= regWrData[ADDR_W-1:MASK_LSB];
          wpR    <= regWrData[WP_BIT];
          disR   <= regWrData[TYPE_W:1];
          validR <= regWrData[0];
        end
      end
    end

    assign addrOk = ((accAddr[ADDR_W-1:MASK_LSB] ^ baseR) & ~maskR) == '0;
    assign typeOk = (accType & disR) == '0;
    assign candidate[i] = validR && addrOk && typeOk;
    assign protect[i] = wpR;

    always_comb begin
      baseView[i] = '0;
      baseView[i][ADDR_W-1:MASK_LSB] = baseR;
      maskView[i] = '0;
      maskView[i][ADDR_W-1:MASK_LSB] = maskR;
      maskView[i][WP_BIT] = wpR;
      maskView[i][TYPE_W:1] = disR;
      maskView[i][0] = validR;
    end

    AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
      !validR |-> !regionHit[i]);  // R5
    AST_HIT_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      regionHit[i] |-> (((accAddr[ADDR_W-1:MASK_LSB] ^ baseR) & ~maskR) == '0));  // R4
    AST_TYPE_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rstN)
      ((accType & disR) != '0) |-> !regionHit[i]);  // R6
    AST_WP_NO_WRITE_HIT: assert property (@(posedge clk) disable iff (!rstN)
      (wpR && accWrite) |-> !regionHit[i]);  // R7
  end

  // Register readback
  always_comb begin
    regRdData = '0;
    for (int i = 0; i < REGION_CNT; i++) begin
      if (strobe.baseRd[i]) regRdData = regRdData | baseView[i];
      if (strobe.maskRd[i]) regRdData = regRdData | maskView[i];
    end
  end

  // Lowest-numbered taking-part region decides
  logic found;
  always_comb begin
    regionHit   = '0;
    wpViolation = 1'b0;
    found       = 1'b0;
    for (int i = 0; i < REGION_CNT; i++) begin
      if (candidate[i] && !found) begin
        found = 1'b1;
        if (accWrite && protect[i]) wpViolation = 1'b1;
        else regionHit[i] = 1'b1;
      end
    end
  end
  assign miss = !found;

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionHit));  // R8
  AST_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    miss |-> (regionHit == '0) && !wpViolation);  // R9
  AST_VIOL_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    wpViolation |-> (regionHit == '0) && accWrite);  // R7
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
  import mem_region_pkg::*;
#(
  parameter int unsigned BASE_OFS = 'h48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [ADDR_W-1:0]     regWrData,
  output logic [ADDR_W-1:0]     regRdData,
  input  logic [ADDR_W-1:0]     accAddr,
  input  logic                  accWrite,
  input  logic [TYPE_W-1:0]     accType,
  output logic [REGION_CNT-1:0] regionHit,
  output logic                  wpViolation,
  output logic                  miss
);
  regStrobe_t strobe;

  mem_region_ctrl #(.BASE_OFS(BASE_OFS)) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  mem_region_match uMatch (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .accAddr     (accAddr),
    .accWrite    (accWrite),
    .accType     (accType),
    .regionHit   (regionHit),
    .wpViolation (wpViolation),
    .miss        (miss)
  );
endmodule

// File: tb/tb_mem_region_decoder.sv
`timescale 1ns/1ps
module tb_mem_region_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic [5:0]  accType = 6'b000001;
  logic [1:0]  regionHit;
  logic        wpViolation;
  logic        miss;

  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  // Reference model state: stored readback values
  logic [31:0] mBase [2];
  logic [31:0] mMask [2];

  localparam logic [31:0] BASE_KEEP = 32'hFFFC_0000;
  localparam logic [31:0] MASK_KEEP = 32'hFFFC_017F;

  always #5 clk = ~clk;

  mem_region_decoder dut (.*);

  function automatic logic [31:0] expRd(logic [7:0] a);
    for (int r = 0; r < 2; r++) begin
      if (a == 8'h48 + 8'(8 * r)) return mBase[r];
      if (a == 8'h4C + 8'(8 * r)) return mMask[r];
    end
    return 32'h0;
  endfunction

  task automatic expAcc(output logic [1:0] h, output logic v, output logic m);
    h = 2'b00; v = 1'b0; m = 1'b1;
    for (int r = 0; r < 2; r++) begin
      bit aOk, tOk;
      aOk = ((accAddr ^ mBase[r]) & ~mMask[r] & BASE_KEEP) == 0;
      tOk = (({26'h0, accType} << 1) & mMask[r] & 32'h7E) == 0;
      if (m && mMask[r][0] && aOk && tOk) begin
        m = 1'b0;
        if (accWrite && mMask[r][8]) v = 1'b1;
        else h[r] = 1'b1;
      end
    end
  endtask

  // Compare in mid-cycle, then let the edge commit any write
  task automatic step(string tag);
    logic [1:0] eh; logic ev, em; logic [31:0] er;
    #1;
    expAcc(eh, ev, em);
    er = expRd(regAddr);
    checkCnt++;
    if (regRdData !== er || regionHit !== eh || wpViolation !== ev || miss !== em) begin
      failCnt++;
      $display("FAIL %s: rd=%h hit=%b wp=%b miss=%b expected rd=%h hit=%b wp=%b miss=%b",
               tag, regRdData, regionHit, wpViolation, miss, er, eh, ev, em);
    end
    @(posedge clk);
    if (regWrEn) begin
      for (int r = 0; r < 2; r++) begin
        if (regAddr == 8'h48 + 8'(8 * r)) mBase[r] = regWrData & BASE_KEEP;
        if (regAddr == 8'h4C + 8'(8 * r)) mMask[r] = regWrData & MASK_KEEP;
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step(tag);
    regWrEn = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, logic w, logic [5:0] t, string tag);
    accAddr = a; accWrite = w; accType = t;
    step(tag);
  endtask

  initial begin
    for (int r = 0; r < 2; r++) begin mBase[r] = '0; mMask[r] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map readback
    foreach (mBase[r]) begin
      regAddr = 8'h48 + 8'(8 * r); step("R1 base reset");
      regAddr = 8'h4C + 8'(8 * r); step("R1 mask reset");
    end
    acc(32'h0, 1'b0, 6'b000001, "R1 miss after reset");

    // R2 and R3 readback, reserved bits clear
    wr(8'h48, 32'h1234_5678, "R2 write base0");
    regAddr = 8'h48; step("R3 base0 readback");
    wr(8'h4C, 32'hFFFF_FFFF, "R2 write mask0");
    regAddr = 8'h4C; step("R3 mask0 readback");
    regAddr = 8'h50; step("R2 base1 unwritten");
    regAddr = 8'h60; step("R2 unmapped reads zero");

    // R4 exact match
    wr(8'h4C, 32'h0000_0001, "R4 mask0 exact");
    acc(32'h1234_4000 | 32'h3FFFF, 1'b0, 6'b000001, "R4 hit inside region");
    acc(32'h1234_4000 ^ 32'h0004_0000, 1'b0, 6'b000001, "R4 miss bit18");
    // R4 non-contiguous mask
    wr(8'h4C, 32'h8010_0001, "R4 mask0 sparse");
    acc(32'h1234_4000 ^ 32'h8010_0000, 1'b0, 6'b000010, "R4 sparse hit");
    acc(32'h1234_4000 ^ 32'h0008_0000, 1'b0, 6'b000010, "R4 sparse miss");

    // R5 valid clear
    wr(8'h4C, 32'h0000_0000, "R5 mask0 invalid");
    acc(32'h1234_4000, 1'b0, 6'b000001, "R5 invalid no hit");
    acc(32'h1234_4000, 1'b1, 6'b000001, "R5 invalid no violation");

    // R6 type disables
    wr(8'h4C, 32'h0000_0041, "R6 disable cpu space");
    acc(32'h1234_4000, 1'b0, 6'b100000, "R6 cpu space blocked");
    acc(32'h1234_4000, 1'b0, 6'b010000, "R6 alt master allowed");
    wr(8'h4C, 32'h0000_0003, "R6 disable user data");
    acc(32'h1234_4000, 1'b0, 6'b000001, "R6 user data blocked");
    acc(32'h1234_4000, 1'b0, 6'b000010, "R6 user code allowed");

    // R7 write protect
    wr(8'h4C, 32'h0000_0101, "R7 protect region0");
    acc(32'h1234_4000, 1'b1, 6'b000001, "R7 write violation");
    acc(32'h1234_4000, 1'b0, 6'b000001, "R7 read still hits");

    // R8 priority with overlapping regions
    wr(8'h50, 32'h1234_4000, "R8 base1 overlap");
    wr(8'h54, 32'h0000_0001, "R8 mask1 valid");
    acc(32'h1234_4000, 1'b1, 6'b000001, "R8 protected region0 shadows region1");
    wr(8'h4C, 32'h0000_0001, "R8 region0 unprotected");
    acc(32'h1234_4000, 1'b0, 6'b000001, "R8 region0 wins");
    wr(8'h4C, 32'h0000_0000, "R8 region0 invalid");
    acc(32'h1234_4000, 1'b1, 6'b000001, "R8 region1 hits");

    // R10 write takes effect next cycle
    accAddr = 32'h1234_4000; accWrite = 1'b0;
    wr(8'h54, 32'h0000_0000, "R10 same cycle old value");
    step("R10 next cycle new value");

    // R9 and general random stream
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 1));
      regWrEn = ($urandom_range(0, 7) == 0);
      regAddr = 8'h48 + 8'(4 * $urandom_range(0, 4));
      regWrData = $urandom;
      if ($urandom_range(0, 1) == 0) regWrData[0] = 1'b1;
      accAddr = $urandom;
      if ($urandom_range(0, 3) != 0)
        accAddr = (mBase[r] ^ ($urandom & mMask[r] & BASE_KEEP)) | ($urandom & 32'h3FFFF);
      accWrite = $urandom_range(0, 1) == 1;
      accType = 6'b000001 << $urandom_range(0, 5);
      step("R4 R6 R7 R8 R9 random");
    end
    regWrEn = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule